// File: doc/BRIEF.md
# Threshold Pixel Sparsifier

This block sits between the digitized readout of a square pixel matrix and the data link. Pixels arrive one per valid cycle in raster order. A start-of-frame marker flags the first pixel of each frame. The block compares every pixel value with a programmable threshold. For each pixel whose value is above that threshold, it emits one self-describing word that holds the pixel's column, its row and its raw sample. Pixels at or below the threshold produce nothing. The link therefore carries only the struck pixels instead of a full frame dump.

Hit words leave through a valid/ready handshake, behind a small first-word-fall-through FIFO that absorbs bursts. The input side never stalls. When the FIFO cannot take a hit, the hit is lost and the loss is counted. At the end of every frame the block reports how many pixels passed the threshold, how many fell at or below it, and how many passing pixels were lost to overflow. With default parameters the matrix is 512 x 512, the samples are 14 bits wide and the FIFO holds 16 words.

Top module: `pix_sparsifier`

## Requirements
- R1: A hit word places the column in its top COORD_W bits, the row in the next COORD_W bits and the raw value in the low VAL_W bits. With default parameters this is column [31:23], row [22:14] and value [13:0].
- R2: A pixel produces a hit word only when its value is strictly greater than the threshold in force. A value equal to or below the threshold produces none.
- R3: Coordinates follow raster order, with the column incrementing fastest. A valid pixel flagged as start-of-frame is at column 0, row 0. The column wraps from its maximum back to 0 and advances the row. After the last pixel, both coordinates return to 0.
- R4: The threshold input is captured by the start-of-frame pixel, and that pixel is judged against the new value. A change of the threshold input later in the frame has no effect until the next start-of-frame.
- R5: While hit_valid_o is high and hit_ready_i is low, hit_valid_o stays high and hit_data_o stays unchanged. Hit words leave in the order their pixels arrived, and hit_valid_o is high exactly when at least one word is stored.
- R6: A passing pixel that meets a FIFO already holding FIFO_DEPTH words at that clock edge is dropped, even if a word leaves on the same edge. The drop adds one to the frame's overflow count and sets ovf_flag_o. The flag stays set until the next start-of-frame pixel clears it, unless that pixel itself overflows.
- R7: frame_done_o pulses for one cycle, in the cycle after the last pixel of the matrix is accepted. In that cycle kept_cnt_o, below_cnt_o and ovf_cnt_o give the finished frame's counts, and they hold until the next pulse. kept counts every passing pixel, including those lost to overflow. kept plus below equals the number of pixels in the matrix. A start-of-frame pixel restarts all running counts.
- R8: pix_ready_o is high in every cycle.
- R9: After reset, hit_valid_o, frame_done_o and ovf_flag_o are low and all three counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof_i | input | 1 | Marks the valid pixel as the first of a frame |
| pix_valid_i | input | 1 | Pixel sample present this cycle |
| pix_value_i | input | VAL_W | Digitized pixel sample |
| pix_ready_o | output | 1 | Always high; the input never stalls |
| thresh_i | input | VAL_W | Threshold, captured at start-of-frame |
| hit_valid_o | output | 1 | Hit word available |
| hit_ready_i | input | 1 | Consumer accepts the hit word |
| hit_data_o | output | 2*COORD_W+VAL_W | Packed column, row and value |
| frame_done_o | output | 1 | One-cycle pulse after the frame's last pixel |
| kept_cnt_o | output | 2*COORD_W+1 | Pixels above threshold in the last frame |
| below_cnt_o | output | 2*COORD_W+1 | Pixels at or below threshold in the last frame |
| ovf_cnt_o | output | 2*COORD_W+1 | Passing pixels lost to overflow in the last frame |
| ovf_flag_o | output | 1 | Sticky flag: overflow seen in the current frame |

## Verification
A raster counter that is off by one shows up at the first hit word after the fault, as a wrong column or row field. A bad running count stays hidden until the frame's end, where the kept and below totals no longer add up to the matrix size. A threshold register that loads at the wrong moment appears only in frames where the threshold input changes mid-frame, on the first pixel whose value lies between the old and the new threshold. A wrong FIFO occupancy shows up in the cycle the FIFO fills: either hit_valid_o drops early or a hit the overflow rule should drop comes out.

// File: rtl/spx_pkg.sv
package spx_pkg;
   localparam int SPX_COORD_W_DEF    = 9;
   localparam int SPX_VAL_W_DEF      = 14;
   localparam int SPX_FIFO_DEPTH_DEF = 16;

   // width of one packed hit word: column, row, value
   function automatic int spx_word_w(input int coord_w, input int val_w);
      return 2 * coord_w + val_w;
   endfunction

   // counters must reach the full pixel count of the matrix
   function automatic int spx_cnt_w(input int coord_w);
      return 2 * coord_w + 1;
   endfunction
endpackage

// File: rtl/spx_raster.sv
module spx_raster #(
   parameter int COORD_W = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               adv_i,
   input  logic               sof_i,
   output logic [COORD_W-1:0] x_o,
   output logic [COORD_W-1:0] y_o,
   output logic               last_o
);
   localparam logic [COORD_W-1:0] MAX_C = '1;

   logic [COORD_W-1:0] x_q, y_q;

   // a start-of-frame pixel is always at the origin
   assign x_o    = sof_i ? '0 : x_q;
   assign y_o    = sof_i ? '0 : y_q;
   assign last_o = (x_o == MAX_C) && (y_o == MAX_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q <= '0;
         y_q <= '0;
      end else if (adv_i) begin
         if (x_o == MAX_C) begin
            x_q <= '0;
            y_q <= y_o + 1'b1;
         end else begin
            x_q <= x_o + 1'b1;
            y_q <= y_o;
         end
      end
   end
endmodule

// File: rtl/spx_gate.sv
module spx_gate #(
   parameter int COORD_W = 9,
   parameter int VAL_W   = 14,
   localparam int WORD_W = 2 * COORD_W + VAL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               valid_i,
   input  logic               sof_i,
   input  logic [VAL_W-1:0]   value_i,
   input  logic [VAL_W-1:0]   thresh_i,
   input  logic [COORD_W-1:0] x_i,
   input  logic [COORD_W-1:0] y_i,
   output logic               hit_o,
   output logic [WORD_W-1:0]  word_o
);
   logic [VAL_W-1:0] thr_q;
   logic [VAL_W-1:0] thr_eff;

   // the frame's first pixel already sees the newly captured threshold
   assign thr_eff = sof_i ? thresh_i : thr_q;
   assign hit_o   = valid_i && (value_i > thr_eff);
   assign word_o  = {x_i, y_i, value_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                thr_q <= '1;
      else if (valid_i && sof_i) thr_q <= thresh_i;
   end
endmodule

// File: rtl/spx_fifo.sv
module spx_fifo #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [WIDTH-1:0] din_i,
   input  logic             pop_i,
   output logic [WIDTH-1:0] dout_o,
   output logic             full_o,
   output logic             empty_o
);
   localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW       = $clog2(DEPTH + 1);
   localparam bit IS_POW2  = (DEPTH == (1 << AW));

   initial assert (DEPTH >= 1 && WIDTH >= 1)
      else $error("spx_fifo: DEPTH and WIDTH must be positive");

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_p, rd_p, wr_nx, rd_nx;
   logic [CW-1:0]    cnt;
   logic             push_ok, pop_ok;

   generate
      if (IS_POW2) begin : g_wrap_free
         assign wr_nx = wr_p + 1'b1;
         assign rd_nx = rd_p + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nx = (wr_p == AW'(DEPTH - 1)) ? '0 : wr_p + 1'b1;
         assign rd_nx = (rd_p == AW'(DEPTH - 1)) ? '0 : rd_p + 1'b1;
      end
   endgenerate

   assign full_o  = (cnt == CW'(DEPTH));
   assign empty_o = (cnt == '0);
   assign push_ok = push_i && !full_o;
   assign pop_ok  = pop_i && !empty_o;
   assign dout_o  = mem[rd_p];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_p] <= din_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_p <= '0;
         rd_p <= '0;
         cnt  <= '0;
      end else begin
         if (push_ok) wr_p <= wr_nx;
         if (pop_ok)  rd_p <= rd_nx;
         case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/spx_frame_stats.sv
module spx_frame_stats #(
   parameter int CNT_W = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid_i,
   input  logic             sof_i,
   input  logic             last_i,
   input  logic             hit_i,
   input  logic             ovf_i,
   output logic             done_o,
   output logic [CNT_W-1:0] kept_o,
   output logic [CNT_W-1:0] below_o,
   output logic [CNT_W-1:0] ovf_cnt_o,
   output logic             flag_o
);
   logic [CNT_W-1:0] kept_r, below_r, ovf_r;
   logic [CNT_W-1:0] kept_n, below_n, ovf_n;

   // start-of-frame discards whatever a broken frame had accumulated
   assign kept_n  = (sof_i ? '0 : kept_r)  + CNT_W'(hit_i);
   assign below_n = (sof_i ? '0 : below_r) + CNT_W'(!hit_i);
   assign ovf_n   = (sof_i ? '0 : ovf_r)   + CNT_W'(ovf_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kept_r    <= '0;
         below_r   <= '0;
         ovf_r     <= '0;
         kept_o    <= '0;
         below_o   <= '0;
         ovf_cnt_o <= '0;
         done_o    <= 1'b0;
         flag_o    <= 1'b0;
      end else begin
         done_o <= valid_i && last_i;
         if (valid_i) begin
            flag_o <= (sof_i ? 1'b0 : flag_o) | ovf_i;
            if (last_i) begin
               kept_o    <= kept_n;
               below_o   <= below_n;
               ovf_cnt_o <= ovf_n;
               kept_r    <= '0;
               below_r   <= '0;
               ovf_r     <= '0;
            end else begin
               kept_r    <= kept_n;
               below_r   <= below_n;
               ovf_r     <= ovf_n;
            end
         end
      end
   end
endmodule

// File: rtl/pix_sparsifier.sv
module pix_sparsifier #(
   parameter int COORD_W    = spx_pkg::SPX_COORD_W_DEF,
   parameter int VAL_W      = spx_pkg::SPX_VAL_W_DEF,
   parameter int FIFO_DEPTH = spx_pkg::SPX_FIFO_DEPTH_DEF
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         sof_i,
   input  logic                         pix_valid_i,
   input  logic [VAL_W-1:0]             pix_value_i,
   output logic                         pix_ready_o,
   input  logic [VAL_W-1:0]             thresh_i,
   output logic                         hit_valid_o,
   input  logic                         hit_ready_i,
   output logic [2*COORD_W+VAL_W-1:0]   hit_data_o,
   output logic                         frame_done_o,
   output logic [2*COORD_W:0]           kept_cnt_o,
   output logic [2*COORD_W:0]           below_cnt_o,
   output logic [2*COORD_W:0]           ovf_cnt_o,
   output logic                         ovf_flag_o
);
   localparam int WORD_W = spx_pkg::spx_word_w(COORD_W, VAL_W);
   localparam int CNT_W  = spx_pkg::spx_cnt_w(COORD_W);

   initial assert (COORD_W >= 1 && VAL_W >= 1 && FIFO_DEPTH >= 1)
      else $error("pix_sparsifier: parameters must be positive");

   logic               sof_v;
   logic [COORD_W-1:0] cx, cy;
   logic               last_px;
   logic               hit;
   logic [WORD_W-1:0]  word;
   logic               fifo_full, fifo_empty;
   logic               ovf_evt;

   assign pix_ready_o = 1'b1;
   assign sof_v       = pix_valid_i && sof_i;

   spx_raster #(.COORD_W(COORD_W)) u_raster (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv_i  (pix_valid_i),
      .sof_i  (sof_v),
      .x_o    (cx),
      .y_o    (cy),
      .last_o (last_px)
   );

   spx_gate #(.COORD_W(COORD_W), .VAL_W(VAL_W)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid_i  (pix_valid_i),
      .sof_i    (sof_v),
      .value_i  (pix_value_i),
      .thresh_i (thresh_i),
      .x_i      (cx),
      .y_i      (cy),
      .hit_o    (hit),
      .word_o   (word)
   );

   // full is judged before any same-edge pop: a hit meeting a full FIFO is lost
   assign ovf_evt = hit && fifo_full;

   spx_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (hit),
      .din_i   (word),
      .pop_i   (hit_ready_i),
      .dout_o  (hit_data_o),
      .full_o  (fifo_full),
      .empty_o (fifo_empty)
   );

   assign hit_valid_o = !fifo_empty;

   spx_frame_stats #(.CNT_W(CNT_W)) u_stats (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_i   (pix_valid_i),
      .sof_i     (sof_v),
      .last_i    (last_px),
      .hit_i     (hit),
      .ovf_i     (ovf_evt),
      .done_o    (frame_done_o),
      .kept_o    (kept_cnt_o),
      .below_o   (below_cnt_o),
      .ovf_cnt_o (ovf_cnt_o),
      .flag_o    (ovf_flag_o)
   );
endmodule

// File: rtl/spx_checker.sv
module spx_checker #(
   parameter int COORD_W    = 9,
   parameter int VAL_W      = 14,
   localparam int WORD_W    = 2 * COORD_W + VAL_W,
   localparam int CNT_W     = 2 * COORD_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pix_valid_i,
   input logic              pix_ready_o,
   input logic              hit_valid_o,
   input logic              hit_ready_i,
   input logic [WORD_W-1:0] hit_data_o,
   input logic              frame_done_o,
   input logic [CNT_W-1:0]  kept_cnt_o,
   input logic [CNT_W-1:0]  below_cnt_o,
   input logic              ovf_flag_o
);
   localparam logic [CNT_W:0] FRAME_PIX = (CNT_W + 1)'(1) << (2 * COORD_W);

   assert_ready_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pix_ready_o);

   assert_hold_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid_o && !hit_ready_i |=> hit_valid_o && $stable(hit_data_o));

   assert_frame_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done_o |-> ({1'b0, kept_cnt_o} + {1'b0, below_cnt_o}) == FRAME_PIX);

   assert_done_after_pixel_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done_o |-> $past(pix_valid_i));

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done_o |=> !frame_done_o);

   assert_flag_needs_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag_o) |-> $past(hit_valid_o));
endmodule

bind pix_sparsifier spx_checker #(.COORD_W(COORD_W), .VAL_W(VAL_W)) u_spx_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pix_valid_i  (pix_valid_i),
   .pix_ready_o  (pix_ready_o),
   .hit_valid_o  (hit_valid_o),
   .hit_ready_i  (hit_ready_i),
   .hit_data_o   (hit_data_o),
   .frame_done_o (frame_done_o),
   .kept_cnt_o   (kept_cnt_o),
   .below_cnt_o  (below_cnt_o),
   .ovf_flag_o   (ovf_flag_o)
);

// File: tb/pix_sparsifier_tb_top.sv
module pix_sparsifier_tb_top;
   localparam int C  = 3;
   localparam int V  = 6;
   localparam int D  = 4;
   localparam int NP = 1 << (2 * C);
   localparam int WW = 2 * C + V;
   localparam int CW = 2 * C + 1;
   localparam int MAXC = (1 << C) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sof_i = 1'b0;
   logic          pix_valid_i = 1'b0;
   logic [V-1:0]  pix_value_i = '0;
   logic          pix_ready_o;
   logic [V-1:0]  thresh_i = '0;
   logic          hit_valid_o;
   logic          hit_ready_i = 1'b0;
   logic [WW-1:0] hit_data_o;
   logic          frame_done_o;
   logic [CW-1:0] kept_cnt_o, below_cnt_o, ovf_cnt_o;
   logic          ovf_flag_o;

   always #5 clk = ~clk;

   pix_sparsifier #(.COORD_W(C), .VAL_W(V), .FIFO_DEPTH(D)) dut_i (
      .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .pix_valid_i(pix_valid_i),
      .pix_value_i(pix_value_i), .pix_ready_o(pix_ready_o), .thresh_i(thresh_i),
      .hit_valid_o(hit_valid_o), .hit_ready_i(hit_ready_i), .hit_data_o(hit_data_o),
      .frame_done_o(frame_done_o), .kept_cnt_o(kept_cnt_o), .below_cnt_o(below_cnt_o),
      .ovf_cnt_o(ovf_cnt_o), .ovf_flag_o(ovf_flag_o)
   );

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   // reference model state
   int occ = 0, qh = 0, qt = 0;
   int qbuf [64];
   int thr_m = (1 << V) - 1;
   int xm = 0, ym = 0;
   int run_k = 0, run_b = 0, run_o = 0;
   int exp_k = 0, exp_b = 0, exp_o = 0;
   bit flag_m = 0, done_pend = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one cycle: check outputs before the edge, update model, drive inputs
   task automatic step(input bit v, input bit s, input int val, input int thr, input bit rdy);
      int eff, cx, cy, wrd, bk, bb, bo;
      bit hit, ovf, push, pop, last;
      @(negedge clk);
      check(pix_ready_o == 1'b1, "R8 ready", int'(pix_ready_o), 1);
      check(hit_valid_o == (occ > 0), "R5 valid", int'(hit_valid_o), int'(occ > 0));
      check(frame_done_o == done_pend, "R7 done pulse", int'(frame_done_o), int'(done_pend));
      if (done_pend) begin
         check(int'(kept_cnt_o) == exp_k, "R7 kept", int'(kept_cnt_o), exp_k);
         check(int'(below_cnt_o) == exp_b, "R7 below", int'(below_cnt_o), exp_b);
         check(int'(ovf_cnt_o) == exp_o, "R6 ovf count", int'(ovf_cnt_o), exp_o);
      end
      check(ovf_flag_o == flag_m, "R6 flag", int'(ovf_flag_o), int'(flag_m));
      pop = (occ > 0) && rdy;
      if (pop)
         check(int'(hit_data_o) == qbuf[qh], "R1 R3 word", int'(hit_data_o), qbuf[qh]);
      // model the coming edge
      eff = s ? thr : thr_m;
      if (v && s) thr_m = thr;
      cx = s ? 0 : xm;
      cy = s ? 0 : ym;
      hit  = v && (val > eff);
      ovf  = hit && (occ == D);
      push = hit && (occ < D);
      last = (cx == MAXC) && (cy == MAXC);
      done_pend = v && last;
      if (v) begin
         bk = (s ? 0 : run_k) + int'(hit);
         bb = (s ? 0 : run_b) + int'(!hit);
         bo = (s ? 0 : run_o) + int'(ovf);
         flag_m = (s ? 1'b0 : flag_m) | ovf;
         if (last) begin
            exp_k = bk; exp_b = bb; exp_o = bo;
            run_k = 0; run_b = 0; run_o = 0;
            xm = 0; ym = 0;
         end else begin
            run_k = bk; run_b = bb; run_o = bo;
            if (cx == MAXC) begin xm = 0; ym = cy + 1; end
            else begin xm = cx + 1; ym = cy; end
         end
      end
      wrd = (cx << (C + V)) | (cy << V) | val;
      if (pop) begin qh = (qh + 1) % 64; occ--; end
      if (push) begin qbuf[qt] = wrd; qt = (qt + 1) % 64; occ++; end
      sof_i = s; pix_valid_i = v; pix_value_i = V'(val);
      thresh_i = V'(thr); hit_ready_i = rdy;
   endtask

   function automatic int pval(input int f, input int p);
      return ((p % 8) * 11 + (p / 8) * 5 + f * 3) % 64;
   endfunction

   // rmode: 0 always ready, 1 every other cycle, 2 never
   task automatic frame(input int f, input int npix, input int thr0, input int thr1,
                        input int rmode, input bit gaps);
      for (int p = 0; p < npix; p++) begin
         bit r;
         int t;
         r = (rmode == 0) ? 1'b1 : (rmode == 1) ? bit'(p % 2) : 1'b0;
         t = (p < 20) ? thr0 : thr1;
         if (gaps && (p % 5 == 2)) step(1'b0, 1'b0, 0, t, r);
         step(1'b1, p == 0, pval(f, p), t, r);
      end
   endtask

   task automatic drain(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, 0, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      check(hit_valid_o == 1'b0, "R9 valid", int'(hit_valid_o), 0);
      check(frame_done_o == 1'b0, "R9 done", int'(frame_done_o), 0);
      check(kept_cnt_o == '0 && below_cnt_o == '0 && ovf_cnt_o == '0, "R9 counts",
            int'(kept_cnt_o) + int'(below_cnt_o) + int'(ovf_cnt_o), 0);
      check(ovf_flag_o == 1'b0, "R9 flag", int'(ovf_flag_o), 0);
      rst_n = 1'b1;
      // R2 mid threshold, equal values present
      frame(0, NP, 31, 31, 0, 1'b0);
      drain(6);
      // R4 threshold change mid-frame ignored; R5 back-pressure; R3 with gaps
      frame(1, NP, 0, 63, 1, 1'b1);
      drain(8);
      // R2 only value 63 passes, 62 does not; R4 mid change to 0 ignored
      frame(2, NP, 62, 0, 0, 1'b0);
      drain(6);
      // R2 nothing passes
      frame(3, NP, 63, 63, 0, 1'b0);
      drain(4);
      // R6 overflow with consumer stalled
      frame(4, NP, 10, 10, 2, 1'b0);
      drain(8);
      // R3 R7 aborted frame then full frame; R6 flag cleared by sof
      frame(5, 20, 5, 5, 2, 1'b0);
      frame(6, NP, 40, 40, 0, 1'b0);
      drain(8);
      // R4 sof pixel itself uses new threshold
      frame(7, NP, 2, 50, 1, 1'b1);
      drain(8);
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule